// File: doc/BRIEF.md
# Muxed Two-Stage Clock Divider

This block produces one clock from a choice of four input clocks. A single 32-bit control register holds three fields. The first picks the input clock. The second sets a power-of-two prescale. The third sets an integer divide of N+1. The output period is the chosen input period, multiplied first by 2^shift and then by (div+1). The total ratio therefore runs from 1 to 256.

The register is written through a simple write port that has byte-lane enables, so each field can be updated without disturbing the others. Its value is always visible on a read bus.

Changes to the input clock go through a break-before-make switch, so the output never carries a runt pulse. Changes to the rate are applied only at the end of the output period that is running at the time.

Top module: `mux_clk_divider`

## Requirements
- R1: After reset the register reads 0x0000_0000, input clock 0 is selected, and once settled clk_o has the period and waveform of src_clk_i[0].
- R2: Field layout: source select in bits [17:16], prescale shift in bits [5:4], divide field in bits [12:8]. wr_be_i[0] enables the shift field, wr_be_i[1] enables the divide field and wr_be_i[2] enables the select field. A write lands on the rising edge of clk_i at which wr_en_i is high.
- R3: All bits outside the three fields read as zero, and writes to them have no effect.
- R4: A read returns each field exactly as it was last written.
- R5: A write whose byte lane for a field is disabled leaves that field unchanged.
- R6: Once settled, the clk_o period equals T_src * 2^shift * (div+1).
- R7: A source change disables the old clock on its falling edge before the new clock is enabled, so clk_o has no high or low pulse shorter than half the period of the faster of the two sources.
- R8: A new shift or divide value takes effect only when the current output period ends, so a period in progress finishes at its old length.
- R9: High time. With div>0 it is floor((div+1)/2)*2^shift source cycles. With div=0 and shift>0 it is 2^(shift-1) source cycles. With a total ratio of 1, clk_o follows the source waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 4 | Byte-lane write enables |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read data |
| src_clk_i | input | 4 | Candidate input clocks, bit index = source number |
| clk_o | output | 1 | Divided output clock |

## Verification
A counter in the divider that holds a wrong value shows up at once as a clk_o period or high time that is off by whole source cycles. It appears in the first period measured after the settle time. A fault in the enable handshake of the source switch shows up during the switch itself as a pulse narrower than half a source period, or as a clock that never restarts. A configuration applied too early cuts short the period that was running when the write arrived, so the bench times the first edge that follows a mid-period write.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned BE_W      = REG_W / 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned SHIFT_W   = 2;
  localparam int unsigned DIV_W     = 5;
  localparam int unsigned SEL_LSB   = 16;
  localparam int unsigned SHIFT_LSB = 4;
  localparam int unsigned DIV_LSB   = 8;
  localparam int unsigned NUM_SRC   = 1 << SEL_W;
  localparam int unsigned PCNT_W    = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;
    logic [DIV_W-1:0]   div;
  } rate_cfg_t;
endpackage

// File: rtl/mcd_ctrl_reg.sv
module mcd_ctrl_reg
  import mcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [SEL_W-1:0] sel_o,
  output rate_cfg_t        rate_o
);
  localparam int unsigned SEL_BYTE   = SEL_LSB / 8;
  localparam int unsigned SHIFT_BYTE = SHIFT_LSB / 8;
  localparam int unsigned DIV_BYTE   = DIV_LSB / 8;

  logic [SEL_W-1:0]   sel_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [DIV_W-1:0]   div_q;
  logic               unused_wr;

  // reserved data bits and lanes are intentionally dropped
  assign unused_wr = ^{wr_data_i, wr_be_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      shift_q <= '0;
      div_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_be_i[SEL_BYTE])   sel_q   <= wr_data_i[SEL_LSB +: SEL_W];
      if (wr_be_i[SHIFT_BYTE]) shift_q <= wr_data_i[SHIFT_LSB +: SHIFT_W];
      if (wr_be_i[DIV_BYTE])   div_q   <= wr_data_i[DIV_LSB +: DIV_W];
    end
  end

  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[SEL_LSB +: SEL_W]       = sel_q;
    rd_data_o[SHIFT_LSB +: SHIFT_W]   = shift_q;
    rd_data_o[DIV_LSB +: DIV_W]       = div_q;
  end

  assign sel_o        = sel_q;
  assign rate_o.shift = shift_q;
  assign rate_o.div   = div_q;

  a_r4_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i[SEL_BYTE]) |=> (sel_o == $past(wr_data_i[SEL_LSB +: SEL_W])));
  a_r5_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_be_i[SEL_BYTE]) |=> $stable(sel_o));
  a_r5_rate_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_be_i[SHIFT_BYTE] && !wr_be_i[DIV_BYTE]) |=> $stable(rate_o));
endmodule

// File: rtl/mcd_glitch_mux.sv
module mcd_glitch_mux #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic                   want;
    logic [NUM_SRC-1:0]     others;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_neg_q;

    always_comb begin
      others    = en_q;
      others[i] = 1'b0;
    end

    // request only once every other branch has released
    assign want = (sel_i == SEL_W'(i)) && (others == '0);

    always_ff @(posedge src_clk_i[i] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], want};
    end

    always_ff @(negedge src_clk_i[i] or negedge rst_ni) begin
      if (!rst_ni) en_neg_q <= 1'b0;
      else         en_neg_q <= sync_q[SYNC_STAGES-1];
    end

    assign en_q[i]  = en_neg_q;
    assign gated[i] = src_clk_i[i] & en_neg_q;
  end

  assign clk_o = |gated;

  always_comb begin
    if (rst_ni) begin
      a_r7_break_before_make: assert ($onehot0(en_q));
    end
  end
endmodule

// File: rtl/mcd_rate_div.sv
module mcd_rate_div
  import mcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rate_cfg_t rate_i,
  output logic      clk_o
);
  rate_cfg_t         stage_q [SYNC_STAGES];
  rate_cfg_t         cur_q, cfg_nxt;
  logic [PCNT_W-1:0] pcnt_q, pcnt_n, pmax, phalf;
  logic [DIV_W-1:0]  dcnt_q, dcnt_n;
  logic [DIV_W:0]    nsum;
  logic              p_end, period_end, cfg_stable;
  logic              hi_q, hi_n, byp_q, byp_n, byp_neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= rate_i;
      for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  // a multi-bit value is taken only after two equal samples
  assign cfg_stable = (stage_q[SYNC_STAGES-1] == stage_q[SYNC_STAGES-2]);

  assign pmax       = PCNT_W'((32'd1 << cur_q.shift) - 32'd1);
  assign p_end      = (pcnt_q == pmax);
  assign period_end = p_end && (dcnt_q == cur_q.div);

  always_comb begin
    cfg_nxt = cur_q;
    pcnt_n  = pcnt_q + PCNT_W'(1);
    dcnt_n  = dcnt_q;
    if (period_end) begin
      if (cfg_stable) cfg_nxt = stage_q[SYNC_STAGES-1];
      pcnt_n = '0;
      dcnt_n = '0;
    end else if (p_end) begin
      pcnt_n = '0;
      dcnt_n = dcnt_q + DIV_W'(1);
    end
  end

  assign phalf = PCNT_W'((32'd1 << cfg_nxt.shift) >> 1);
  assign nsum  = {1'b0, cfg_nxt.div} + (DIV_W+1)'(1);
  assign byp_n = (cfg_nxt.div == '0) && (cfg_nxt.shift == '0);

  always_comb begin
    if (cfg_nxt.div != '0)        hi_n = ({1'b0, dcnt_n} < (nsum >> 1));
    else if (cfg_nxt.shift != '0) hi_n = (pcnt_n < phalf);
    else                          hi_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      pcnt_q <= '0;
      dcnt_q <= '0;
      hi_q   <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      cur_q  <= cfg_nxt;
      pcnt_q <= pcnt_n;
      dcnt_q <= dcnt_n;
      hi_q   <= hi_n;
      byp_q  <= byp_n;
    end
  end

  // bypass gate only moves while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_neg_q <= 1'b0;
    else         byp_neg_q <= byp_q;
  end

  assign clk_o = hi_q | (clk_i & byp_neg_q);

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> $stable(cur_q));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> (pcnt_q == '0 && dcnt_q == '0));
  a_r6_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcnt_q <= cur_q.div) && (pcnt_q <= pmax));
  a_r6_div_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_end && !period_end) |=> (dcnt_q == $past(dcnt_q) + DIV_W'(1)));
endmodule

// File: rtl/mux_clk_divider.sv
module mux_clk_divider
  import mcd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BE_W-1:0]    wr_be_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [NUM_SRC-1:0] src_clk_i,
  output logic               clk_o
);
  logic [SEL_W-1:0] sel;
  rate_cfg_t        rate;
  logic             mux_clk;

  mcd_ctrl_reg i_ctrl_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_be_i   (wr_be_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .sel_o     (sel),
    .rate_o    (rate)
  );

  mcd_glitch_mux #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_glitch_mux (
    .src_clk_i (src_clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .clk_o     (mux_clk)
  );

  mcd_rate_div #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_rate_div (
    .clk_i  (mux_clk),
    .rst_ni (rst_ni),
    .rate_i (rate),
    .clk_o  (clk_o)
  );
endmodule

// File: tb/test_mux_clk_divider.sv
`timescale 1ns/1ps
module test_mux_clk_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  src_clk_i = '0;
  logic        clk_o;

  int  n_vec = 0;
  int  n_bad = 0;
  real old_span = 3584.0;
  real mon_last = -1.0;
  real mon_min  = 1.0e9;
  bit  mon_on   = 1'b0;

  mux_clk_divider i_mux_clk_divider (
    .clk_i, .rst_ni, .wr_en_i, .wr_be_i, .wr_data_i, .rd_data_o, .src_clk_i, .clk_o
  );

  always #4.0 clk_i = ~clk_i;

  function automatic real src_t(input int s);
    case (s)
      0:       return 4.0;
      1:       return 6.0;
      2:       return 10.0;
      default: return 14.0;
    endcase
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_clk
    initial forever #(src_t(g) / 2.0) src_clk_i[g] = ~src_clk_i[g];
  end

  always @(posedge clk_o or negedge clk_o) begin
    if (mon_on) begin
      if (mon_last >= 0.0 && ($realtime - mon_last) < mon_min) mon_min = $realtime - mon_last;
      mon_last = $realtime;
    end
  end

  task automatic chk_int(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_real(input string req, input real act, input real exp);
    n_vec++;
    if (act < exp - 0.05 || act > exp + 0.05) begin
      n_bad++;
      $display("FAIL %s: got %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic chk_min(input string req, input real act, input real lo);
    n_vec++;
    if (act < lo - 0.01) begin
      n_bad++;
      $display("FAIL %s: min pulse %0.3f expected >= %0.3f", req, act, lo);
    end
  endtask

  task automatic reg_write(input logic [3:0] be, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_be_i = be; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0; wr_data_i = '0;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic mon_start();
    @(posedge clk_o);
    #1;
    mon_last = -1.0; mon_min = 1.0e9; mon_on = 1'b1;
  endtask

  task automatic set_cfg(input int s, input int sh, input int dv);
    real span;
    reg_write(4'b0111, (32'(s) << 16) | (32'(dv) << 8) | (32'(sh) << 4));
    span = src_t(s) * real'(1 << sh) * real'(dv + 1);
    #(2.0 * old_span + 2.0 * span + 150.0);
    old_span = span;
  endtask

  task automatic t_reset();
    real per, hi;
    chk_int("R1 reset readback", rd_data_o, 32'h0);
    #200;
    measure(per, hi);
    chk_real("R1 reset period", per, 4.0);
    chk_real("R1 reset high", hi, 2.0);
  endtask

  task automatic t_regs();
    reg_write(4'hF, 32'hFFFF_FFFF);
    chk_int("R2 R3 full write", rd_data_o, 32'h0003_1F30);
    reg_write(4'b0100, 32'h0001_0000);
    chk_int("R5 select lane only", rd_data_o, 32'h0001_1F30);
    reg_write(4'b0011, 32'h0002_0A20);
    chk_int("R5 rate lanes only", rd_data_o, 32'h0001_0A20);
    reg_write(4'b1000, 32'hFFFF_FFFF);
    chk_int("R3 reserved lane ignored", rd_data_o, 32'h0001_0A20);
    reg_write(4'b0111, 32'h0002_1310);
    chk_int("R4 readback", rd_data_o, 32'h0002_1310);
    old_span = 3584.0;
  endtask

  task automatic t_sweep();
    real per, hi, t, exp_hi;
    int  dv;
    for (int s = 0; s < 4; s++) begin
      for (int sh = 0; sh < 4; sh++) begin
        for (int di = 0; di < 4; di++) begin
          dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 15 : 31;
          set_cfg(s, sh, dv);
          t = src_t(s);
          measure(per, hi);
          chk_real($sformatf("R6 period s%0d sh%0d dv%0d", s, sh, dv), per,
                   t * real'(1 << sh) * real'(dv + 1));
          if (dv > 0)      exp_hi = real'((dv + 1) / 2) * real'(1 << sh) * t;
          else if (sh > 0) exp_hi = real'(1 << (sh - 1)) * t;
          else             exp_hi = t / 2.0;
          chk_real($sformatf("R9 high s%0d sh%0d dv%0d", s, sh, dv), hi, exp_hi);
        end
      end
    end
  endtask

  task automatic t_src_switch();
    real per, hi;
    set_cfg(0, 0, 0);
    mon_start();
    reg_write(4'b0100, 32'h0003_0000);
    #300;
    reg_write(4'b0100, 32'h0001_0000);
    #300;
    measure(per, hi);
    mon_on = 1'b0;
    chk_min("R7 no runt on source switch", mon_min, 2.0);
    chk_real("R7 period after switch", per, 6.0);
    old_span = 14.0;
  endtask

  task automatic t_rate_change();
    real t_r, t_n, per, hi;
    set_cfg(2, 3, 31);
    @(posedge clk_o);
    t_r = $realtime;
    #1;
    mon_last = -1.0; mon_min = 1.0e9; mon_on = 1'b1;
    #500;
    reg_write(4'b0011, 32'h0000_0100);
    @(posedge clk_o);
    t_n = $realtime;
    chk_real("R8 old period completes", t_n - t_r, 2560.0);
    measure(per, hi);
    mon_on = 1'b0;
    chk_real("R8 new period", per, 20.0);
    chk_min("R8 no short pulse on rate change", mon_min, 10.0);
    old_span = 20.0;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_sweep();
    t_src_switch();
    t_rate_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule